// File: doc/BRIEF.md
# Context Switch Controller

This block holds the register-selection state of a small processor whose calls and interrupts do not push a return address. It owns the two 4-bit selectors, X for the data pointer and P for the program counter, which pick one of sixteen 16-bit scratchpad registers. It also owns an 8-bit save byte T and the interrupt enable flag IE. A context switch changes which register plays each role. The old selector pair is kept as a single byte, with X in bits 7:4 and P in bits 3:0.

An outside fetch/decode stage presents one opcode per instruction boundary on `opValid`/`opcode`. The block carries out the opcodes it owns in that same cycle: set-P, set-X, mark, return, disable and save. It also performs the interrupt entry action. Each of these takes a single clock. Memory is reached through a byte port whose read data is combinational, and the write commits at the clock edge. The register file is written through a load port by the rest of the datapath and is read through a read port.

Top module: `ctx_switch_ctrl`

## Requirements
- R1: Interrupt entry: in the cycle after acceptance, T holds the previous {X,P}, P is 1, X is 2, IE is 0, and `intAck` is high for exactly that one cycle. No register in the file changes.
- R2: An interrupt is accepted only when `opValid`, `intReq` and IE are all 1. When it is accepted, the opcode presented in the same cycle is not executed. With IE at 0, or with `opValid` low, a request has no effect.
- R3: Mark (0x79) writes {X,P} to the byte addressed by R2 and copies {X,P} into T. It sets X to the old P and decrements R2 by one. P and IE are unchanged.
- R4: Return (0x70) reads the byte addressed by R(X) and loads X from its bits 7:4 and P from its bits 3:0. It increments the old R(X) by one and sets IE to 1.
- R5: Disable (0x71) does the same as return but clears IE.
- R6: Save (0x78) writes T to the byte addressed by R(X). X, P, T, IE and every register are left unchanged.
- R7: Opcode 0xDn sets P to n, and opcode 0xEn sets X to n. Nothing else changes.
- R8: Any other opcode leaves X, P, T, IE, every register and memory unchanged.
- R9: While `rstN` is low, X, P, T and IE are cleared, all sixteen registers (R0 included) are cleared, and `intAck` is 0.
- R10: `memWe` is high only during a mark or a save. For a mark, `memAddr` is R2; otherwise it is R(X).
- R11: The load port writes `rfWdata` into register `rfWaddr` at the clock edge. If an operation updates the same register in that cycle, the operation's value wins. `rdData` always shows register `rdSel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Instruction boundary: `opcode` is presented this cycle |
| opcode | input | 8 | Opcode to execute |
| intReq | input | 1 | Interrupt request level |
| memRdata | input | 8 | Byte read from `memAddr` (combinational) |
| rfWe | input | 1 | Register load strobe |
| rfWaddr | input | 4 | Register load index |
| rfWdata | input | 16 | Register load value |
| rdSel | input | 4 | Register read index |
| memAddr | output | 16 | Byte address |
| memWdata | output | 8 | Byte to write |
| memWe | output | 1 | Byte write strobe |
| xSel | output | 4 | Data pointer selector X |
| pSel | output | 4 | Program counter selector P |
| tReg | output | 8 | Save byte T |
| ieFlag | output | 1 | Interrupt enable |
| intAck | output | 1 | One-cycle pulse after interrupt entry |
| rdData | output | 16 | Contents of register `rdSel` |

## Verification
On every cycle, the assertions check several things. They check the selector and T values that follow an interrupt entry, a mark, a return or disable, and a set-P. They check that an acknowledge is never raised unless IE was set. They check the R2 decrement on mark, the write strobe and data on save, and that save leaves the selectors and T untouched. Only the bench scenarios can show certain end-to-end results. These are: the bytes actually landing in memory, the increment of the register that was R(X), precedence of an interrupt over the opcode presented with it, opcodes outside the set having no effect, and the load port losing a same-cycle conflict.

// File: rtl/cxs_pkg.sv
package cxs_pkg;
  // selector width fixes the register count and the {X,P} byte layout
  localparam int SEL_W    = 4;
  localparam int REGS     = 1 << SEL_W;
  localparam int BYTE_W   = 2 * SEL_W;

  localparam logic [BYTE_W-1:0] OP_RET  = 8'h70;
  localparam logic [BYTE_W-1:0] OP_DIS  = 8'h71;
  localparam logic [BYTE_W-1:0] OP_SAV  = 8'h78;
  localparam logic [BYTE_W-1:0] OP_MARK = 8'h79;
  localparam logic [SEL_W-1:0]  GRP_SETP = 4'hD;
  localparam logic [SEL_W-1:0]  GRP_SETX = 4'hE;

  localparam logic [SEL_W-1:0] INT_P    = 4'd1;
  localparam logic [SEL_W-1:0] INT_X    = 4'd2;
  localparam int               MARK_PTR = 2;

  typedef struct packed {
    logic             takeInt;
    logic             doMark;
    logic             doRestore;
    logic             newIe;
    logic             doSave;
    logic             setP;
    logic             setX;
    logic [SEL_W-1:0] nib;
  } ctlStrobe_t;
endpackage

// File: rtl/cxs_ctrl.sv
module cxs_ctrl
  import cxs_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [BYTE_W-1:0] opcode,
  input  logic              intReq,
  input  logic              ieFlag,
  output ctlStrobe_t        ctl
);
  logic [SEL_W-1:0] opGroup;
  assign opGroup = opcode[BYTE_W-1:SEL_W];

  always_comb begin
    ctl     = '0;
    ctl.nib = opcode[SEL_W-1:0];
    if (opValid) begin
      if (intReq && ieFlag) begin
        ctl.takeInt = 1'b1;
      end else begin
        case (opcode)
          OP_MARK: ctl.doMark = 1'b1;
          OP_SAV:  ctl.doSave = 1'b1;
          OP_RET: begin
            ctl.doRestore = 1'b1;
            ctl.newIe     = 1'b1;
          end
          OP_DIS:  ctl.doRestore = 1'b1;
          default: begin
            ctl.setP = (opGroup == GRP_SETP);
            ctl.setX = (opGroup == GRP_SETX);
          end
        endcase
      end
    end
  end

  // R2
  int_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && intReq && !ieFlag) |-> !ctl.takeInt);

  // R2
  int_blocks_op_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.takeInt |-> !(ctl.doMark || ctl.doSave || ctl.doRestore || ctl.setP || ctl.setX));
endmodule

// File: rtl/cxs_dpath.sv
module cxs_dpath
  import cxs_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        ctl,
  input  logic [BYTE_W-1:0] memRdata,
  input  logic              rfWe,
  input  logic [SEL_W-1:0]  rfWaddr,
  input  logic [ADDR_W-1:0] rfWdata,
  input  logic [SEL_W-1:0]  rdSel,
  output logic [ADDR_W-1:0] memAddr,
  output logic [BYTE_W-1:0] memWdata,
  output logic              memWe,
  output logic [SEL_W-1:0]  xSel,
  output logic [SEL_W-1:0]  pSel,
  output logic [BYTE_W-1:0] tReg,
  output logic              ieFlag,
  output logic              intAck,
  output logic [ADDR_W-1:0] rdData
);
  logic [ADDR_W-1:0] rf [REGS];
  logic [ADDR_W-1:0] xPtr;
  logic [ADDR_W-1:0] markPtr;
  logic [BYTE_W-1:0] selPair;

  assign xPtr     = rf[xSel];
  assign markPtr  = rf[MARK_PTR];
  assign selPair  = {xSel, pSel};
  assign rdData   = rf[rdSel];
  assign memAddr  = ctl.doMark ? markPtr : xPtr;
  assign memWe    = ctl.doMark | ctl.doSave;
  assign memWdata = ctl.doMark ? selPair : tReg;

  // selector, save byte and enable state
  always_ff @(posedge clk) begin
    if (!rstN) begin
      xSel   <= '0;
      pSel   <= '0;
      tReg   <= '0;
      ieFlag <= 1'b0;
      intAck <= 1'b0;
    end else begin
      intAck <= ctl.takeInt;
      if (ctl.takeInt) begin
        tReg   <= selPair;
        pSel   <= INT_P;
        xSel   <= INT_X;
        ieFlag <= 1'b0;
      end else if (ctl.doMark) begin
        tReg <= selPair;
        xSel <= pSel;
      end else if (ctl.doRestore) begin
        xSel   <= memRdata[BYTE_W-1:SEL_W];
        pSel   <= memRdata[SEL_W-1:0];
        ieFlag <= ctl.newIe;
      end else if (ctl.setP) begin
        pSel <= ctl.nib;
      end else if (ctl.setX) begin
        xSel <= ctl.nib;
      end
    end
  end

  // scratchpad registers, one process per entry
  for (genvar i = 0; i < REGS; i++) begin : g_reg
    logic [ADDR_W-1:0] regQ;
    logic              markHit;
    logic              restoreHit;
    assign markHit    = ctl.doMark && (i == MARK_PTR);
    assign restoreHit = ctl.doRestore && (xSel == SEL_W'(i));
    always_ff @(posedge clk) begin
      if (!rstN) begin
        regQ <= '0;
      end else if (markHit) begin
        regQ <= regQ - 1'b1;
      end else if (restoreHit) begin
        regQ <= regQ + 1'b1;
      end else if (rfWe && (rfWaddr == SEL_W'(i))) begin
        regQ <= rfWdata;
      end
    end
    assign rf[i] = regQ;
  end

  // R1
  int_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.takeInt |=> (pSel == INT_P) && (xSel == INT_X) && !ieFlag && intAck
                    && (tReg == $past(selPair)));

  // R2
  ack_needs_ie_chk: assert property (@(posedge clk) disable iff (!rstN)
    intAck |-> !ieFlag && ($past(ieFlag) || $past(intAck) == 1'b0 && $past(ieFlag)));

  // R3
  mark_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.doMark |=> (xSel == $past(pSel)) && (pSel == $past(pSel))
                   && (rf[MARK_PTR] == $past(markPtr) - 1'b1));

  // R4
  restore_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.doRestore |=> (selPair == $past(memRdata)) && (ieFlag == $past(ctl.newIe)));

  // R6
  save_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.doSave |-> memWe && (memWdata == tReg) && (memAddr == xPtr));

  // R6
  save_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.doSave |=> $stable(selPair) && $stable(tReg) && $stable(ieFlag));

  // R7
  set_p_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.setP |=> (pSel == $past(ctl.nib)) && $stable(xSel));

  // R10
  we_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> ctl.doMark || ctl.doSave);
endmodule

// File: rtl/ctx_switch_ctrl.sv
module ctx_switch_ctrl
  import cxs_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [BYTE_W-1:0] opcode,
  input  logic              intReq,
  input  logic [BYTE_W-1:0] memRdata,
  input  logic              rfWe,
  input  logic [SEL_W-1:0]  rfWaddr,
  input  logic [ADDR_W-1:0] rfWdata,
  input  logic [SEL_W-1:0]  rdSel,
  output logic [ADDR_W-1:0] memAddr,
  output logic [BYTE_W-1:0] memWdata,
  output logic              memWe,
  output logic [SEL_W-1:0]  xSel,
  output logic [SEL_W-1:0]  pSel,
  output logic [BYTE_W-1:0] tReg,
  output logic              ieFlag,
  output logic              intAck,
  output logic [ADDR_W-1:0] rdData
);
  ctlStrobe_t ctl;

  cxs_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .opValid (opValid),
    .opcode  (opcode),
    .intReq  (intReq),
    .ieFlag  (ieFlag),
    .ctl     (ctl)
  );

  cxs_dpath #(.ADDR_W(ADDR_W)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .memRdata (memRdata),
    .rfWe     (rfWe),
    .rfWaddr  (rfWaddr),
    .rfWdata  (rfWdata),
    .rdSel    (rdSel),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .memWe    (memWe),
    .xSel     (xSel),
    .pSel     (pSel),
    .tReg     (tReg),
    .ieFlag   (ieFlag),
    .intAck   (intAck),
    .rdData   (rdData)
  );
endmodule

// File: tb/ctx_switch_ctrl_test.sv
module ctx_switch_ctrl_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [7:0]  opcode = '0;
  logic        intReq = 1'b0;
  logic [7:0]  memRdata;
  logic        rfWe = 1'b0;
  logic [3:0]  rfWaddr = '0;
  logic [15:0] rfWdata = '0;
  logic [3:0]  rdSel = '0;
  logic [15:0] memAddr;
  logic [7:0]  memWdata;
  logic        memWe;
  logic [3:0]  xSel, pSel;
  logic [7:0]  tReg;
  logic        ieFlag, intAck;
  logic [15:0] rdData;

  ctx_switch_ctrl uut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opcode(opcode), .intReq(intReq),
    .memRdata(memRdata), .rfWe(rfWe), .rfWaddr(rfWaddr), .rfWdata(rfWdata),
    .rdSel(rdSel), .memAddr(memAddr), .memWdata(memWdata), .memWe(memWe),
    .xSel(xSel), .pSel(pSel), .tReg(tReg), .ieFlag(ieFlag), .intAck(intAck),
    .rdData(rdData)
  );

  always #2 clk = ~clk;

  // byte memory seen by the design
  logic [7:0] mem [256];
  assign memRdata = mem[memAddr[7:0]];
  always @(posedge clk) if (memWe) mem[memAddr[7:0]] <= memWdata;

  // reference model state
  logic [3:0]  mx, mp;
  logic [7:0]  mt;
  logic        mie;
  logic [15:0] mr [16];
  logic [7:0]  mm [256];

  typedef struct {
    string      rq;
    logic [3:0] x, p;
    logic [7:0] t;
    logic       ie, ack;
  } exp_t;
  exp_t q[$];

  int total = 0;
  int bad = 0;

  task automatic chk(string rq, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // monitor: compares registered outputs one cycle after each driven op
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t it;
        it = q.pop_front();
        chk(it.rq, "xSel", 32'(xSel), 32'(it.x));
        chk(it.rq, "pSel", 32'(pSel), 32'(it.p));
        chk(it.rq, "tReg", 32'(tReg), 32'(it.t));
        chk(it.rq, "ieFlag", 32'(ieFlag), 32'(it.ie));
        chk(it.rq, "intAck", 32'(intAck), 32'(it.ack));
      end
    end
  end

  // driver: one cycle per call, optional load-port write alongside
  task automatic doOp(string rq, logic v, logic [7:0] opc, logic irq,
                      logic we = 1'b0, logic [3:0] wa = '0, logic [15:0] wd = '0);
    logic take;
    int   opReg;
    logic [7:0] b;
    exp_t it;
    @(negedge clk);
    opValid = v; opcode = opc; intReq = irq;
    rfWe = we; rfWaddr = wa; rfWdata = wd;
    opReg = -1;
    take  = v && irq && mie;
    if (take) begin
      mt = {mx, mp}; mp = 4'd1; mx = 4'd2; mie = 1'b0;
    end else if (v) begin
      if (opc == 8'h79) begin
        mm[mr[2][7:0]] = {mx, mp};
        mt = {mx, mp}; mx = mp; mr[2] = mr[2] - 1; opReg = 2;
      end else if (opc == 8'h70 || opc == 8'h71) begin
        b = mm[mr[mx][7:0]];
        mr[mx] = mr[mx] + 1; opReg = int'(mx);
        mx = b[7:4]; mp = b[3:0]; mie = (opc == 8'h70);
      end else if (opc == 8'h78) begin
        mm[mr[mx][7:0]] = mt;
      end else if (opc[7:4] == 4'hD) begin
        mp = opc[3:0];
      end else if (opc[7:4] == 4'hE) begin
        mx = opc[3:0];
      end
    end
    if (we && int'(wa) != opReg) mr[wa] = wd;
    it.rq = rq; it.x = mx; it.p = mp; it.t = mt; it.ie = mie; it.ack = take;
    q.push_back(it);
  endtask

  task automatic idle();
    @(negedge clk);
    opValid = 1'b0; intReq = 1'b0; rfWe = 1'b0;
  endtask

  task automatic loadReg(logic [3:0] i, logic [15:0] v);
    doOp("R11", 1'b0, 8'h00, 1'b0, 1'b1, i, v);
  endtask

  task automatic ckReg(string rq, logic [3:0] i);
    rdSel = i;
    #1;
    chk(rq, $sformatf("reg%0d", i), 32'(rdData), 32'(mr[i]));
  endtask

  task automatic ckMem(string rq, logic [7:0] a);
    chk(rq, $sformatf("mem%0h", a), 32'(mem[a]), 32'(mm[a]));
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i ^ 8'hA5);
      mm[i]  = 8'(i ^ 8'hA5);
    end
    for (int i = 0; i < 16; i++) mr[i] = '0;
    mx = '0; mp = '0; mt = '0; mie = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R9 reset state
    chk("R9", "xSel", 32'(xSel), 0);
    chk("R9", "pSel", 32'(pSel), 0);
    chk("R9", "tReg", 32'(tReg), 0);
    chk("R9", "ieFlag", 32'(ieFlag), 0);
    chk("R9", "intAck", 32'(intAck), 0);
    ckReg("R9", 4'd0);

    // R11 loads
    loadReg(4'd0, 16'h0010);
    loadReg(4'd2, 16'h0040);
    loadReg(4'd3, 16'h0050);
    loadReg(4'd5, 16'h0060);
    loadReg(4'd1, 16'h0070);
    idle();
    ckReg("R11", 4'd3);
    ckReg("R11", 4'd5);

    // R7 selector set
    doOp("R7", 1'b1, 8'hE3, 1'b0);
    doOp("R7", 1'b1, 8'hD5, 1'b0);
    // R2 request with IE clear, R8 unknown opcode
    doOp("R2", 1'b1, 8'hC4, 1'b1);
    idle();
    ckMem("R8", 8'h50);

    // R4 return through R3
    mem[8'h50] = 8'h3C; mm[8'h50] = 8'h3C;
    doOp("R4", 1'b1, 8'h70, 1'b0);
    idle();
    ckReg("R4", 4'd3);

    // R2 request without boundary is ignored
    doOp("R2", 1'b0, 8'hD2, 1'b1);
    // R1 interrupt wins over set-P
    doOp("R1", 1'b1, 8'hD2, 1'b1);
    idle();
    ckReg("R1", 4'd2);

    // R3 mark, R10 address is R2
    doOp("R3", 1'b1, 8'h79, 1'b0);
    idle();
    ckMem("R3", 8'h40);
    ckReg("R3", 4'd2);

    // R6 save via R(X)=R1
    doOp("R6", 1'b1, 8'h78, 1'b0);
    idle();
    ckMem("R6", 8'h70);
    ckReg("R6", 4'd1);

    // R5 disable through R3
    mem[8'h51] = 8'h95; mm[8'h51] = 8'h95;
    doOp("R7", 1'b1, 8'hE3, 1'b0);
    doOp("R5", 1'b1, 8'h71, 1'b0);
    idle();
    ckReg("R5", 4'd3);

    // R4 return via R5 enables, then R1 interrupt over mark
    mem[8'h60] = 8'h56; mm[8'h60] = 8'h56;
    doOp("R7", 1'b1, 8'hE5, 1'b0);
    doOp("R4", 1'b1, 8'h70, 1'b0);
    doOp("R1", 1'b1, 8'h79, 1'b1);
    idle();
    ckReg("R1", 4'd2);
    ckMem("R1", 8'h3F);

    // R8 other opcodes do nothing
    doOp("R8", 1'b1, 8'h72, 1'b0);
    doOp("R8", 1'b1, 8'h7A, 1'b0);
    doOp("R8", 1'b1, 8'h60, 1'b0);
    idle();
    ckReg("R8", 4'd2);
    ckMem("R8", 8'h3F);

    // R11 conflict: mark and load of R2 together, mark wins
    doOp("R11", 1'b1, 8'h79, 1'b0, 1'b1, 4'd2, 16'h1234);
    idle();
    ckReg("R11", 4'd2);
    ckMem("R10", 8'h3F);

    repeat (3) idle();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 20000);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule